// File: doc/BRIEF.md
# Timer Event Interrupt Status Unit

This block gathers the events of a four-channel timer into one 32-bit status word and drives a single interrupt request. Each channel has a 16-bit up/down counter, whose value and direction the block watches. A step across the top or bottom of the range raises a wrap event. Each channel also compares a shared free-running timer against its own time value, and this match raises a compare event only while the channel is in timer mode. The two lowest channels also have an input pin. After synchronisation, a rising or a falling edge on that pin raises an edge event, and a per-channel polarity bit chooses which.

Every event sets a sticky bit. The bit stays set until software writes a 0 to it through a single-cycle read/write port. Writing a 1 leaves a bit as it was. A 32-bit enable mask chooses which set bits may raise the interrupt. The interrupt comes from a register, so it follows the masked status one cycle later.

Top module: `tmr_evt_irq`

## Requirements
- R1: The readable bits other than 11..8, 7..4 and 1..0 (that is, 31..12 and 3..2) always read 0. Writing 1 to them has no effect.
- R2: When channel c counts up (cnt_down[c]=0) and its value steps from 0xFFFF to 0x0000, bit 8+c is set on the next clock edge.
- R3: When channel c counts down (cnt_down[c]=1) and its value steps from 0x0000 to 0xFFFF, the same bit 8+c is set.
- R4: With tmr_mode[c]=1, bit 4+c is set once, on the first cycle that tmr_frt equals channel c's time value. Staying equal does not set it again after it has been cleared.
- R5: A match on a channel with tmr_mode[c]=0 leaves bit 4+c clear.
- R6: Edge channel e (0 or 1) sets bit e three clock edges after its input changes, if the change is the active edge. The active edge is rising when edge_pol[e]=0 and falling when edge_pol[e]=1. The other edge is ignored.
- R7: A set bit stays set across cycles without a write, and across a write that carries 1 in its position.
- R8: A write clears exactly the status bits whose write-data bit is 0.
- R9: If an event and a write with 0 hit the same bit in the same cycle, the bit ends up set.
- R10: irq is 1 in the cycle after (rd_data & irq_mask) is non-zero and 0 in the cycle after it is zero.
- R11: After reset, rd_data is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 64 | Current counter values, channel c in bits 16c+15..16c |
| cnt_down | input | 4 | Counting direction per channel, 1 = down |
| tmr_frt | input | 16 | Free-running timer value |
| ch_time | input | 64 | Per-channel time values, channel c in bits 16c+15..16c |
| tmr_mode | input | 4 | Timer mode per channel, enables compare events |
| edge_in | input | 2 | Asynchronous edge inputs for channels 0 and 1 |
| edge_pol | input | 2 | Active edge per input, 0 = rising, 1 = falling |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data; a 0 clears the matching status bit |
| rd_data | output | 32 | Current status word |
| irq_mask | input | 32 | Per-bit interrupt enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is an event and a clearing write arriving in the same cycle. For this, the bench loads a counter with 0xFFFF and then, on one falling clock edge, drives the counter to 0x0000 and asserts a write of all zeros. The write also covers a compare bit that was set before, so one result shows both that the wrapped bit survives and that the other bit is cleared. The edge path is also probed one cycle before its expected latency, which shows that the synchroniser stages are really present.

// File: rtl/tei_pkg.sv
package tei_pkg;
   // Active edge selection for the edge channels
   typedef enum logic {
      POL_RISE = 1'b0,
      POL_FALL = 1'b1
   } tei_pol_e;

   // Fixed field anchors of the status word; the wrap field follows the compare field
   localparam int unsigned EDGE_LSB = 0;
   localparam int unsigned CMP_LSB  = 4;
endpackage

// File: rtl/tei_wrap_det.sv
module tei_wrap_det #(
   parameter int unsigned CH_NUM = 4,
   parameter int unsigned CNT_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      arm,
   input  logic [CH_NUM*CNT_W-1:0]   cnt_val,
   input  logic [CH_NUM-1:0]         cnt_down,
   output logic [CH_NUM-1:0]         wrap_evt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_MIN = '0;

   for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
      logic [CNT_W-1:0] prev_q;
      logic [CNT_W-1:0] cur;
      logic             up_wrap;
      logic             dn_wrap;

      assign cur = cnt_val[c*CNT_W +: CNT_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= '0;
         else        prev_q <= cur;
      end

      assign up_wrap     = !cnt_down[c] && (prev_q == CNT_MAX) && (cur == CNT_MIN);
      assign dn_wrap     =  cnt_down[c] && (prev_q == CNT_MIN) && (cur == CNT_MAX);
      assign wrap_evt[c] = arm && (up_wrap || dn_wrap);
   end
endmodule

// File: rtl/tei_cmp_det.sv
module tei_cmp_det #(
   parameter int unsigned CH_NUM = 4,
   parameter int unsigned CNT_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      arm,
   input  logic [CNT_W-1:0]          tmr_frt,
   input  logic [CH_NUM*CNT_W-1:0]   ch_time,
   input  logic [CH_NUM-1:0]         tmr_mode,
   output logic [CH_NUM-1:0]         cmp_evt
);
   for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
      logic eq_now;
      logic eq_q;

      assign eq_now = (tmr_frt == ch_time[c*CNT_W +: CNT_W]);

      // Equality history is kept regardless of mode so a match never fires late
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) eq_q <= 1'b0;
         else        eq_q <= eq_now;
      end

      assign cmp_evt[c] = arm && tmr_mode[c] && eq_now && !eq_q;
   end
endmodule

// File: rtl/tei_edge_det.sv
module tei_edge_det #(
   parameter int unsigned EDGE_CH     = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [EDGE_CH-1:0] edge_in,
   input  logic [EDGE_CH-1:0] edge_pol,
   output logic [EDGE_CH-1:0] edge_evt
);
   import tei_pkg::*;

   localparam int unsigned HIST_W = SYNC_STAGES + 1;

   for (genvar e = 0; e < EDGE_CH; e++) begin : g_edge
      logic [HIST_W-1:0] hist_q;
      logic              cur_lvl;
      logic              old_lvl;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_q <= '0;
         else        hist_q <= {hist_q[HIST_W-2:0], edge_in[e]};
      end

      assign cur_lvl = hist_q[SYNC_STAGES-1];
      assign old_lvl = hist_q[SYNC_STAGES];

      always_comb begin
         if (edge_pol[e] == POL_FALL) edge_evt[e] = !cur_lvl &&  old_lvl;
         else                         edge_evt[e] =  cur_lvl && !old_lvl;
      end
   end
endmodule

// File: rtl/tei_status_reg.sv
module tei_status_reg #(
   parameter int unsigned       REG_W = 32,
   parameter logic [REG_W-1:0]  WMASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set_vec,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic [REG_W-1:0] irq_mask,
   output logic [REG_W-1:0] status,
   output logic             irq
);
   logic [REG_W-1:0] status_q;
   logic [REG_W-1:0] kept;
   logic             irq_q;

   // Write of 0 clears, write of 1 keeps; new events override the clear
   always_comb begin
      kept = wr_en ? (status_q & wr_data) : status_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= (kept | set_vec) & WMASK;
         irq_q    <= |(status_q & irq_mask);
      end
   end

   assign status = status_q;
   assign irq    = irq_q;
endmodule

// File: rtl/tmr_evt_irq.sv
module tmr_evt_irq #(
   parameter int unsigned CH_NUM      = 4,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned EDGE_CH     = 2,
   parameter int unsigned REG_W       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CH_NUM*CNT_W-1:0]  cnt_val,
   input  logic [CH_NUM-1:0]        cnt_down,
   input  logic [CNT_W-1:0]         tmr_frt,
   input  logic [CH_NUM*CNT_W-1:0]  ch_time,
   input  logic [CH_NUM-1:0]        tmr_mode,
   input  logic [EDGE_CH-1:0]       edge_in,
   input  logic [EDGE_CH-1:0]       edge_pol,
   input  logic                     wr_en,
   input  logic [REG_W-1:0]         wr_data,
   output logic [REG_W-1:0]         rd_data,
   input  logic [REG_W-1:0]         irq_mask,
   output logic                     irq
);
   import tei_pkg::*;

   localparam int unsigned WRAP_LSB = CMP_LSB + CH_NUM;
   localparam logic [REG_W-1:0] EDGE_ONES = {{(REG_W-EDGE_CH){1'b0}}, {EDGE_CH{1'b1}}};
   localparam logic [REG_W-1:0] CH_ONES   = {{(REG_W-CH_NUM){1'b0}}, {CH_NUM{1'b1}}};
   localparam logic [REG_W-1:0] WMASK     = (EDGE_ONES << EDGE_LSB)
                                          | (CH_ONES << CMP_LSB)
                                          | (CH_ONES << WRAP_LSB);

   // Elaboration-time parameter checks
   if (CH_NUM < 1 || CNT_W < 2) begin : g_bad_ch
      $error("tmr_evt_irq: CH_NUM must be >= 1 and CNT_W >= 2");
   end
   if (EDGE_CH < 1 || EDGE_CH > CH_NUM || EDGE_LSB + EDGE_CH > CMP_LSB) begin : g_bad_edge
      $error("tmr_evt_irq: EDGE_CH out of range");
   end
   if (WRAP_LSB + CH_NUM > REG_W) begin : g_bad_regw
      $error("tmr_evt_irq: REG_W too small for the status fields");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_evt_irq: SYNC_STAGES must be >= 2");
   end

   // Gates the value/equality histories for the first cycle after reset
   logic arm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= 1'b0;
      else        arm_q <= 1'b1;
   end

   logic [CH_NUM-1:0]  wrap_evt;
   logic [CH_NUM-1:0]  cmp_evt;
   logic [EDGE_CH-1:0] edge_evt;
   logic [REG_W-1:0]   set_vec;

   tei_wrap_det #(.CH_NUM(CH_NUM), .CNT_W(CNT_W)) u_wrap (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm_q),
      .cnt_val  (cnt_val),
      .cnt_down (cnt_down),
      .wrap_evt (wrap_evt)
   );

   tei_cmp_det #(.CH_NUM(CH_NUM), .CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (arm_q),
      .tmr_frt  (tmr_frt),
      .ch_time  (ch_time),
      .tmr_mode (tmr_mode),
      .cmp_evt  (cmp_evt)
   );

   tei_edge_det #(.EDGE_CH(EDGE_CH), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_in  (edge_in),
      .edge_pol (edge_pol),
      .edge_evt (edge_evt)
   );

   always_comb begin
      set_vec = '0;
      set_vec[EDGE_LSB +: EDGE_CH] = edge_evt;
      set_vec[CMP_LSB  +: CH_NUM]  = cmp_evt;
      set_vec[WRAP_LSB +: CH_NUM]  = wrap_evt;
   end

   tei_status_reg #(.REG_W(REG_W), .WMASK(WMASK)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .irq_mask (irq_mask),
      .status   (rd_data),
      .irq      (irq)
   );
endmodule

// File: rtl/tei_irq_chk.sv
module tei_irq_chk #(
   parameter int unsigned      REG_W = 32,
   parameter logic [REG_W-1:0] WMASK = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] irq_mask,
   input logic [REG_W-1:0] rd_data,
   input logic             irq
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~WMASK) == '0);                                                  // R1

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((rd_data & $past(rd_data)) == $past(rd_data)));                 // R7

   AST_WRITE_ONE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((rd_data & $past(rd_data & wr_data)) == $past(rd_data & wr_data))); // R7

   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rd_data & irq_mask)) |=> irq);                                           // R10

   AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(rd_data & irq_mask)) |=> !irq);                                         // R10
endmodule

bind tmr_evt_irq tei_irq_chk #(.REG_W(REG_W), .WMASK(WMASK)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .irq_mask (irq_mask),
   .rd_data  (rd_data),
   .irq      (irq)
);

// File: tb/tmr_evt_irq_test.sv
module tmr_evt_irq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt_val = '0;
   logic [3:0]  cnt_down = '0;
   logic [15:0] tmr_frt = '0;
   logic [63:0] ch_time = {16'h4003, 16'h4002, 16'h4001, 16'h4000};
   logic [3:0]  tmr_mode = '0;
   logic [1:0]  edge_in = '0;
   logic [1:0]  edge_pol = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [31:0] irq_mask = '0;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tmr_evt_irq uut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
      .tmr_frt(tmr_frt), .ch_time(ch_time), .tmr_mode(tmr_mode),
      .edge_in(edge_in), .edge_pol(edge_pol), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq_mask(irq_mask), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d;
      step(1);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic set_cnt(input int ch, input logic [15:0] v);
      cnt_val[ch*16 +: 16] = v;
   endtask

   task automatic t_reset();
      chk("R11 status after reset", rd_data, 32'h0);
      chk("R11 irq after reset", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_reserved();
      wr(32'hFFFF_FFFF);
      chk("R1 write of ones sets nothing", rd_data, 32'h0);
   endtask

   task automatic t_wrap_up();
      set_cnt(2, 16'hFFFE); step(1);
      set_cnt(2, 16'hFFFF); step(1);
      chk("R2 no flag before wrap", rd_data, 32'h0);
      set_cnt(2, 16'h0000); step(1);
      chk("R2 up wrap ch2", rd_data, 32'h0000_0400);
      wr(32'h0);
      chk("R8 clear after up wrap", rd_data, 32'h0);
   endtask

   task automatic t_wrap_down();
      cnt_down[1] = 1'b1;
      set_cnt(1, 16'h0000); step(1);
      set_cnt(1, 16'hFFFF); step(1);
      chk("R3 down wrap ch1", rd_data, 32'h0000_0200);
      wr(32'h0);
      // FFFF -> 0000 while counting down is not a wrap
      set_cnt(1, 16'h0000); step(1);
      chk("R3 no wrap on reverse step", rd_data, 32'h0);
      cnt_down[1] = 1'b0;
   endtask

   task automatic t_cmp_once();
      tmr_mode[3] = 1'b1;
      ch_time[48 +: 16] = 16'h1234;
      tmr_frt = 16'h1234; step(1);
      chk("R4 compare ch3 first match", rd_data, 32'h0000_0080);
      wr(32'h0);
      step(2);
      chk("R4 no repeat while equal", rd_data, 32'h0);
      tmr_frt = 16'h1235; step(1);
      tmr_frt = 16'h1234; step(1);
      chk("R4 new match sets again", rd_data, 32'h0000_0080);
      wr(32'h0);
      tmr_frt = 16'h0000; tmr_mode[3] = 1'b0; step(1);
   endtask

   task automatic t_cmp_mode_off();
      ch_time[0 +: 16] = 16'h0042;
      tmr_frt = 16'h0042; step(2);
      chk("R5 match ignored outside timer mode", rd_data, 32'h0);
      tmr_frt = 16'h0000; step(1);
   endtask

   task automatic t_edge_rise();
      edge_pol[0] = 1'b0;
      edge_in[0] = 1'b1; step(2);
      chk("R6 edge not yet through synchroniser", rd_data, 32'h0);
      step(1);
      chk("R6 rising edge ch0", rd_data, 32'h0000_0001);
      wr(32'h0);
      edge_in[0] = 1'b0; step(4);
      chk("R6 falling ignored with rising polarity", rd_data, 32'h0);
   endtask

   task automatic t_edge_fall();
      edge_pol[1] = 1'b1;
      edge_in[1] = 1'b1; step(4);
      chk("R6 rising ignored with falling polarity", rd_data, 32'h0);
      edge_in[1] = 1'b0; step(3);
      chk("R6 falling edge ch1", rd_data, 32'h0000_0002);
      wr(32'h0);
      edge_pol[1] = 1'b0;
      step(1);
   endtask

   task automatic t_sticky_partial();
      set_cnt(0, 16'hFFFF); tmr_mode[3] = 1'b1; ch_time[48 +: 16] = 16'h0777; step(1);
      set_cnt(0, 16'h0000); tmr_frt = 16'h0777; step(1);
      chk("R2 wrap ch0 with compare ch3", rd_data, 32'h0000_0180);
      step(3);
      chk("R7 bits hold without write", rd_data, 32'h0000_0180);
      wr(32'hFFFF_FFFF);
      chk("R7 write of ones keeps bits", rd_data, 32'h0000_0180);
      wr(~32'h0000_0080);
      chk("R8 only zero-written bit cleared", rd_data, 32'h0000_0100);
      wr(32'h0);
      tmr_frt = 16'h0000; tmr_mode[3] = 1'b0; step(1);
   endtask

   task automatic t_collision();
      tmr_mode[2] = 1'b1; ch_time[32 +: 16] = 16'h0500;
      tmr_frt = 16'h0500; step(1);
      chk("R4 compare ch2 before collision", rd_data, 32'h0000_0040);
      set_cnt(2, 16'hFFFF); step(1);
      set_cnt(2, 16'h0000);
      wr(32'h0);
      chk("R9 event beats clearing write", rd_data, 32'h0000_0400);
      wr(32'h0);
      tmr_frt = 16'h0000; tmr_mode[2] = 1'b0; step(1);
   endtask

   task automatic t_irq();
      irq_mask = 32'h0000_0100;
      set_cnt(0, 16'hFFFF); step(1);
      set_cnt(0, 16'h0000); step(1);
      chk("R10 status set, irq not yet", {rd_data[8], irq}, 32'h2);
      step(1);
      chk("R10 irq asserted", {31'h0, irq}, 32'h1);
      wr(32'h0);
      chk("R10 irq one cycle after clear", {31'h0, irq}, 32'h1);
      step(1);
      chk("R10 irq released", {31'h0, irq}, 32'h0);
      tmr_mode[1] = 1'b1; tmr_frt = 16'h4001; step(3);
      chk("R10 masked bit gives no irq", {rd_data[5], irq}, 32'h2);
      wr(32'h0);
      tmr_frt = 16'h0000; tmr_mode[1] = 1'b0; irq_mask = '0; step(1);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(3);
      t_reset();
      t_reserved();
      t_wrap_up();
      t_wrap_down();
      t_cmp_once();
      t_cmp_mode_off();
      t_edge_rise();
      t_edge_fall();
      t_sticky_partial();
      t_collision();
      t_irq();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule